// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

This block sits between an 8-bit processor and the memories and peripherals of a handheld-style system. It looks at a 16-bit byte address and decides which region the access belongs to. The regions are the cartridge ROM space, video RAM, cartridge external RAM, two work RAM banks, an echo of work RAM, the sprite attribute table, the I/O register page, high RAM and the interrupt-enable register. It raises at most one region select. It passes on a local address, which is translated for the echo range, and a gated write enable. It returns the read byte of the selected region through a registered output.

A small boot ROM overlays the bottom 256 bytes of the cartridge space for reads. A single write of a nonzero byte to one I/O address removes the overlay until the next reset. The current display mode decides whether video RAM and the sprite table may be touched. Regions that are absent or blocked return fixed fill values and drop writes. The memories and peripherals behind the selects are outside this block. Their read data comes in on per-region input buses.

Top module: `addr_router`

## Requirements
- R1: After reset the boot overlay is mapped and `rdData` is 0xFF. While mapped, a read (`cpuWe`=0) of 0x0000–0x00FF raises `bootSel` and returns `bootData`. Writes in that range go to the cartridge instead.
- R2: A write of a nonzero byte to 0xFF50 unmaps the overlay from the next cycle until reset. A write of zero there leaves it mapped. Once unmapped, reads of 0x0000–0x00FF go to the cartridge.
- R3: With `cartPresent`=1, 0x0000–0x7FFF (outside the overlay) raises `cartSel` and 0xA000–0xBFFF raises `xramSel`. With `cartPresent`=0 neither select rises, writes are dropped and reads return 0xFF.
- R4: 0xC000–0xCFFF raises `wram0Sel` and 0xD000–0xDFFF raises `wramNSel`. In both cases `memAddr` equals the address.
- R5: For 0xE000–0xFDFF, `memAddr` = 0xC000 + (address AND 0x1FFF). A masked value below 0x1000 raises `wram0Sel`; otherwise `wramNSel` rises.
- R6: `dispMode` is encoded 0 = hblank, 1 = vblank, 2 = sprite search, 3 = drawing. Video RAM (0x8000–0x9FFF) raises `vramSel` in modes 0–2. In mode 3 it is not selected, writes are dropped and reads return 0xFF.
- R7: The sprite table (0xFE00–0xFE9F) raises `oamSel` only in modes 0 and 1. In modes 2 and 3 it is not selected, writes are dropped and reads return 0xFF.
- R8: 0xFEA0–0xFEFF never raises a select or `memWe`. It reads 0x00 in modes 0 and 1 and 0xFF in modes 2 and 3.
- R9: 0xFF00–0xFF7F raises `ioSel` for every write. For a read it raises `ioSel` only at implemented offsets (low byte 0x00–0x02, 0x04–0x07, 0x0F, 0x10–0x4B). A read at any other offset returns 0xFF.
- R10: 0xFF80–0xFFFE raises `hramSel` and 0xFFFF raises `ieSel`.
- R11: `rdData` is registered. The byte for an address presented before a clock edge appears after that edge.
- R12: At most one select is high at a time. `memWe` is high exactly when `cpuWe` is high and a select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Byte address |
| cpuWe | input | 1 | Write strobe (0 = read) |
| cpuWdata | input | 8 | Write data |
| dispMode | input | 2 | Display mode, encoded as in R6 |
| cartPresent | input | 1 | Cartridge inserted |
| bootData | input | 8 | Boot ROM read data |
| cartData | input | 8 | Cartridge ROM read data |
| vramData | input | 8 | Video RAM read data |
| xramData | input | 8 | External RAM read data |
| wram0Data | input | 8 | Work RAM bank 0 read data |
| wramNData | input | 8 | Switchable work RAM bank read data |
| oamData | input | 8 | Sprite table read data |
| ioData | input | 8 | I/O register read data |
| hramData | input | 8 | High RAM read data |
| ieData | input | 8 | Interrupt-enable register read data |
| bootSel | output | 1 | Boot ROM selected |
| cartSel | output | 1 | Cartridge ROM selected |
| vramSel | output | 1 | Video RAM selected |
| xramSel | output | 1 | External RAM selected |
| wram0Sel | output | 1 | Work RAM bank 0 selected |
| wramNSel | output | 1 | Switchable work RAM bank selected |
| oamSel | output | 1 | Sprite table selected |
| ioSel | output | 1 | I/O page selected |
| hramSel | output | 1 | High RAM selected |
| ieSel | output | 1 | Interrupt-enable register selected |
| memAddr | output | 16 | Local address, translated in the echo range |
| memWe | output | 1 | Gated write enable |
| rdData | output | 8 | Registered read data |

## Verification
Directed accesses hit both ends of every range, for example 0x00FF/0x0100, 0xDFFF/0xE000, 0xEFFF/0xF000, 0xFDFF/0xFE00, 0xFE9F/0xFEA0, 0xFF7F/0xFF80 and 0xFFFF. These separate off-by-one range decoding from correct decoding. The display-gated ranges are tried in all four modes, which separates sprite search (video RAM open, sprite table closed) from drawing. The boot-disable register is written first with zero and then with a nonzero value, to separate a sticky nonzero-only unmap from one that reacts to any write. Random addresses, modes, cartridge states and read data across many cycles catch wrong mux steering, because every region sees a different data byte each cycle.

// File: rtl/addr_router_pkg.sv
package addr_router_pkg;

  // Selectable regions come first; their value is their select index.
  typedef enum logic [3:0] {
    RG_BOOT  = 4'd0,
    RG_CART  = 4'd1,
    RG_VRAM  = 4'd2,
    RG_XRAM  = 4'd3,
    RG_WRAM0 = 4'd4,
    RG_WRAMN = 4'd5,
    RG_OAM   = 4'd6,
    RG_IO    = 4'd7,
    RG_HRAM  = 4'd8,
    RG_IE    = 4'd9,
    RG_FILL1 = 4'd10,  // nothing selected, reads all ones
    RG_FILL0 = 4'd11   // nothing selected, reads all zeros
  } region_e;

  localparam int NUM_SEL = 10;

  typedef struct packed {
    region_e region;
    logic    echo;   // address needs mirror translation
    logic    wrEn;   // write reaches a selected region
  } strobes_t;

  // Display mode encoding
  localparam logic [1:0] MODE_HBLANK = 2'd0;
  localparam logic [1:0] MODE_VBLANK = 2'd1;
  localparam logic [1:0] MODE_SEARCH = 2'd2;
  localparam logic [1:0] MODE_DRAW   = 2'd3;

endpackage

// File: rtl/router_ctrl.sv
module router_ctrl
  import addr_router_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BOOT_BYTES = 256,
  parameter logic [127:0] IO_MAP = 128'h0000_0000_0000_0FFF_FFFF_FFFF_FFFF_80F7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [1:0]        dispMode,
  input  logic              cartPresent,
  output strobes_t          strobes
);

  localparam logic [ADDR_W-1:0] ROM_END   = ADDR_W'('h7FFF);
  localparam logic [ADDR_W-1:0] VRAM_END  = ADDR_W'('h9FFF);
  localparam logic [ADDR_W-1:0] XRAM_END  = ADDR_W'('hBFFF);
  localparam logic [ADDR_W-1:0] WRAM0_END = ADDR_W'('hCFFF);
  localparam logic [ADDR_W-1:0] WRAMN_END = ADDR_W'('hDFFF);
  localparam logic [ADDR_W-1:0] ECHO_END  = ADDR_W'('hFDFF);
  localparam logic [ADDR_W-1:0] OAM_END   = ADDR_W'('hFE9F);
  localparam logic [ADDR_W-1:0] GAP_END   = ADDR_W'('hFEFF);
  localparam logic [ADDR_W-1:0] IO_END    = ADDR_W'('hFF7F);
  localparam logic [ADDR_W-1:0] HRAM_END  = ADDR_W'('hFFFE);
  localparam logic [ADDR_W-1:0] BOOT_END  = ADDR_W'(BOOT_BYTES - 1);
  localparam logic [ADDR_W-1:0] ECHO_MASK = ADDR_W'('h1FFF);
  localparam logic [ADDR_W-1:0] ECHO_SPLIT = ADDR_W'('h1000);
  localparam logic [ADDR_W-1:0] UNMAP_ADDR = ADDR_W'('hFF50);

  logic bootMapped;
  logic blankMode;
  logic vramOpen;
  logic [ADDR_W-1:0] maskedAddr;
  logic ioImpl;
  region_e region;
  logic echo;

  assign blankMode  = (dispMode == MODE_HBLANK) || (dispMode == MODE_VBLANK);
  assign vramOpen   = (dispMode != MODE_DRAW);
  assign maskedAddr = cpuAddr & ECHO_MASK;
  assign ioImpl     = IO_MAP[cpuAddr[6:0]];

  // Boot overlay flag: cleared by a nonzero write to the unmap register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootMapped <= 1'b1;
    end else if (cpuWe && (cpuAddr == UNMAP_ADDR) && (cpuWdata != '0)) begin
      bootMapped <= 1'b0;
    end
  end

  // Region decode with mode and presence gating
  always_comb begin
    region = RG_FILL1;
    echo   = 1'b0;
    if (cpuAddr <= ROM_END) begin
      if (!cpuWe && bootMapped && (cpuAddr <= BOOT_END)) begin
        region = RG_BOOT;
      end else if (cartPresent) begin
        region = RG_CART;
      end
    end else if (cpuAddr <= VRAM_END) begin
      if (vramOpen) region = RG_VRAM;
    end else if (cpuAddr <= XRAM_END) begin
      if (cartPresent) region = RG_XRAM;
    end else if (cpuAddr <= WRAM0_END) begin
      region = RG_WRAM0;
    end else if (cpuAddr <= WRAMN_END) begin
      region = RG_WRAMN;
    end else if (cpuAddr <= ECHO_END) begin
      echo   = 1'b1;
      region = (maskedAddr < ECHO_SPLIT) ? RG_WRAM0 : RG_WRAMN;
    end else if (cpuAddr <= OAM_END) begin
      if (blankMode) region = RG_OAM;
    end else if (cpuAddr <= GAP_END) begin
      region = blankMode ? RG_FILL0 : RG_FILL1;
    end else if (cpuAddr <= IO_END) begin
      if (cpuWe || ioImpl) region = RG_IO;
    end else if (cpuAddr <= HRAM_END) begin
      region = RG_HRAM;
    end else begin
      region = RG_IE;
    end
  end

  always_comb begin
    strobes.region = region;
    strobes.echo   = echo;
    strobes.wrEn   = cpuWe && (region != RG_FILL1) && (region != RG_FILL0);
  end

endmodule

// File: rtl/router_dpath.sv
module router_dpath
  import addr_router_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobes_t                       strobes,
  input  logic [ADDR_W-1:0]              cpuAddr,
  input  logic [NUM_SEL-1:0][DATA_W-1:0] regData,
  output logic [NUM_SEL-1:0]             selVec,
  output logic [ADDR_W-1:0]              memAddr,
  output logic                           memWe,
  output logic [DATA_W-1:0]              rdData
);

  localparam logic [ADDR_W-1:0] ECHO_BASE = ADDR_W'('hC000);
  localparam logic [ADDR_W-1:0] ECHO_MASK = ADDR_W'('h1FFF);

  logic [DATA_W-1:0] rdNext;

  // One select line per selectable region
  for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_sel
    assign selVec[gi] = (strobes.region == region_e'(gi));
  end

  assign memAddr = strobes.echo ? (ECHO_BASE + (cpuAddr & ECHO_MASK)) : cpuAddr;
  assign memWe   = strobes.wrEn;

  always_comb begin
    rdNext = (strobes.region == RG_FILL0) ? '0 : '1;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (selVec[i]) rdNext = regData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '1;
    end else begin
      rdData <= rdNext;
    end
  end

endmodule

// File: rtl/addr_router.sv
module addr_router
  import addr_router_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BOOT_BYTES = 256,
  parameter logic [127:0] IO_MAP = 128'h0000_0000_0000_0FFF_FFFF_FFFF_FFFF_80F7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [1:0]        dispMode,
  input  logic              cartPresent,
  input  logic [DATA_W-1:0] bootData,
  input  logic [DATA_W-1:0] cartData,
  input  logic [DATA_W-1:0] vramData,
  input  logic [DATA_W-1:0] xramData,
  input  logic [DATA_W-1:0] wram0Data,
  input  logic [DATA_W-1:0] wramNData,
  input  logic [DATA_W-1:0] oamData,
  input  logic [DATA_W-1:0] ioData,
  input  logic [DATA_W-1:0] hramData,
  input  logic [DATA_W-1:0] ieData,
  output logic              bootSel,
  output logic              cartSel,
  output logic              vramSel,
  output logic              xramSel,
  output logic              wram0Sel,
  output logic              wramNSel,
  output logic              oamSel,
  output logic              ioSel,
  output logic              hramSel,
  output logic              ieSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] rdData
);

  strobes_t strobes;
  logic [NUM_SEL-1:0]             selVec;
  logic [NUM_SEL-1:0][DATA_W-1:0] regData;

  assign regData[RG_BOOT]  = bootData;
  assign regData[RG_CART]  = cartData;
  assign regData[RG_VRAM]  = vramData;
  assign regData[RG_XRAM]  = xramData;
  assign regData[RG_WRAM0] = wram0Data;
  assign regData[RG_WRAMN] = wramNData;
  assign regData[RG_OAM]   = oamData;
  assign regData[RG_IO]    = ioData;
  assign regData[RG_HRAM]  = hramData;
  assign regData[RG_IE]    = ieData;

  router_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_BYTES(BOOT_BYTES), .IO_MAP(IO_MAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuWdata(cpuWdata), .dispMode(dispMode), .cartPresent(cartPresent),
    .strobes(strobes)
  );

  router_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .regData(regData), .selVec(selVec), .memAddr(memAddr),
    .memWe(memWe), .rdData(rdData)
  );

  assign bootSel  = selVec[RG_BOOT];
  assign cartSel  = selVec[RG_CART];
  assign vramSel  = selVec[RG_VRAM];
  assign xramSel  = selVec[RG_XRAM];
  assign wram0Sel = selVec[RG_WRAM0];
  assign wramNSel = selVec[RG_WRAMN];
  assign oamSel   = selVec[RG_OAM];
  assign ioSel    = selVec[RG_IO];
  assign hramSel  = selVec[RG_HRAM];
  assign ieSel    = selVec[RG_IE];

endmodule

// File: rtl/addr_router_chk.sv
module addr_router_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuAddr,
  input logic        cpuWe,
  input logic [1:0]  dispMode,
  input logic        cartPresent,
  input logic [7:0]  ieData,
  input logic [7:0]  hramData,
  input logic        bootSel,
  input logic        cartSel,
  input logic        vramSel,
  input logic        xramSel,
  input logic        wram0Sel,
  input logic        wramNSel,
  input logic        oamSel,
  input logic        ioSel,
  input logic        hramSel,
  input logic        ieSel,
  input logic [15:0] memAddr,
  input logic        memWe,
  input logic [7:0]  rdData
);

  logic [9:0] sels;
  assign sels = {ieSel, hramSel, ioSel, oamSel, wramNSel, wram0Sel,
                 xramSel, vramSel, cartSel, bootSel};

  a_r12_onehot_sel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sels));

  a_r12_we_gated: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (cpuWe && (sels != '0)));

  a_r1_boot_low_reads: assert property (@(posedge clk) disable iff (!rstN)
    bootSel |-> (!cpuWe && (cpuAddr < 16'h0100)));

  a_r3_no_cart: assert property (@(posedge clk) disable iff (!rstN)
    !cartPresent |-> (!cartSel && !xramSel));

  a_r5_echo_xlate: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr >= 16'hE000 && cpuAddr <= 16'hFDFF) |->
      ((memAddr[15:13] == 3'b110) && (memAddr[12:0] == cpuAddr[12:0]) &&
       (wram0Sel || wramNSel)));

  a_r6_vram_draw_block: assert property (@(posedge clk) disable iff (!rstN)
    (dispMode == 2'd3) |-> !vramSel);

  a_r7_oam_block: assert property (@(posedge clk) disable iff (!rstN)
    dispMode[1] |-> !oamSel);

  a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr >= 16'hFEA0 && cpuAddr <= 16'hFEFF) |-> (sels == '0 && !memWe));

  a_r11_ie_latency: assert property (@(posedge clk) disable iff (!rstN)
    (ieSel && !cpuWe) |=> (rdData == $past(ieData)));

  a_r10_hram_latency: assert property (@(posedge clk) disable iff (!rstN)
    (hramSel && !cpuWe) |=> (rdData == $past(hramData)));

endmodule

bind addr_router addr_router_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
  .dispMode(dispMode), .cartPresent(cartPresent), .ieData(ieData),
  .hramData(hramData), .bootSel(bootSel), .cartSel(cartSel),
  .vramSel(vramSel), .xramSel(xramSel), .wram0Sel(wram0Sel),
  .wramNSel(wramNSel), .oamSel(oamSel), .ioSel(ioSel), .hramSel(hramSel),
  .ieSel(ieSel), .memAddr(memAddr), .memWe(memWe), .rdData(rdData)
);

// File: tb/addr_router_tb.sv
`timescale 1ns/1ps
module addr_router_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic cpuWe = 1'b0;
  logic [7:0] cpuWdata = '0;
  logic [1:0] dispMode = '0;
  logic cartPresent = 1'b1;
  logic [7:0] dIn [10];
  logic bootSel, cartSel, vramSel, xramSel, wram0Sel, wramNSel;
  logic oamSel, ioSel, hramSel, ieSel, memWe;
  logic [15:0] memAddr;
  logic [7:0] rdData;

  int nChecks = 0;
  int nFails = 0;
  bit mapped = 1'b1;

  always #4 clk = ~clk;  // 125 MHz

  addr_router u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuWdata(cpuWdata), .dispMode(dispMode), .cartPresent(cartPresent),
    .bootData(dIn[0]), .cartData(dIn[1]), .vramData(dIn[2]),
    .xramData(dIn[3]), .wram0Data(dIn[4]), .wramNData(dIn[5]),
    .oamData(dIn[6]), .ioData(dIn[7]), .hramData(dIn[8]), .ieData(dIn[9]),
    .bootSel(bootSel), .cartSel(cartSel), .vramSel(vramSel),
    .xramSel(xramSel), .wram0Sel(wram0Sel), .wramNSel(wramNSel),
    .oamSel(oamSel), .ioSel(ioSel), .hramSel(hramSel), .ieSel(ieSel),
    .memAddr(memAddr), .memWe(memWe), .rdData(rdData)
  );

  function automatic bit ioImpl(input logic [7:0] off);
    return (off <= 8'h02) || (off >= 8'h04 && off <= 8'h07) ||
           (off == 8'h0F) || (off >= 8'h10 && off <= 8'h4B);
  endfunction

  // Expected select index: 0 boot,1 cart,2 vram,3 xram,4 wram0,5 wramN,
  // 6 oam,7 io,8 hram,9 ie, -1 none
  function automatic int expSel(input logic [15:0] a, input bit we,
                                input logic [1:0] m, input bit cart,
                                input bit mp);
    bit blank;
    blank = (m < 2'd2);
    if (a <= 16'h7FFF) begin
      if (!we && mp && a <= 16'h00FF) return 0;
      return cart ? 1 : -1;
    end
    if (a <= 16'h9FFF) return (m == 2'd3) ? -1 : 2;
    if (a <= 16'hBFFF) return cart ? 3 : -1;
    if (a <= 16'hCFFF) return 4;
    if (a <= 16'hDFFF) return 5;
    if (a <= 16'hFDFF) return ((a & 16'h1FFF) < 16'h1000) ? 4 : 5;
    if (a <= 16'hFE9F) return blank ? 6 : -1;
    if (a <= 16'hFEFF) return -1;
    if (a <= 16'hFF7F) return (we || ioImpl(a[7:0])) ? 7 : -1;
    if (a <= 16'hFFFE) return 8;
    return 9;
  endfunction

  function automatic logic [7:0] expRd(input logic [15:0] a, input int idx,
                                       input logic [1:0] m);
    if (idx >= 0) return dIn[idx];
    if (a >= 16'hFEA0 && a <= 16'hFEFF && m < 2'd2) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [15:0] expAddr(input logic [15:0] a);
    if (a >= 16'hE000 && a <= 16'hFDFF) return 16'hC000 + (a & 16'h1FFF);
    return a;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One access: drive at negedge, check strobes, then check registered read
  task automatic access(input string req, input logic [15:0] a, input bit we,
                        input logic [7:0] wd, input logic [1:0] m,
                        input bit cart);
    int idx;
    logic [9:0] selAct, selExp;
    logic [7:0] rdExp;
    @(negedge clk);
    cpuAddr = a; cpuWe = we; cpuWdata = wd; dispMode = m; cartPresent = cart;
    for (int i = 0; i < 10; i++) dIn[i] = 8'($urandom);
    #1;
    idx = expSel(a, we, m, cart, mapped);
    selExp = (idx >= 0) ? (10'b1 << idx) : '0;
    selAct = {ieSel, hramSel, ioSel, oamSel, wramNSel, wram0Sel,
              xramSel, vramSel, cartSel, bootSel};
    check(req, "select", 32'(selAct), 32'(selExp));
    check("R12", "memWe", 32'(memWe), 32'(we && idx >= 0));
    check(req, "memAddr", 32'(memAddr), 32'(expAddr(a)));
    rdExp = expRd(a, idx, m);
    @(posedge clk);
    if (we && a == 16'hFF50 && wd != 8'h00) mapped = 1'b0;
    #1;
    if (!we) check(req, "rdData", 32'(rdData), 32'(rdExp));
  endtask

  initial begin
    #1600000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) dIn[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset rdData", 32'(rdData), 32'hFF);
    @(negedge clk);
    rstN = 1'b1;

    // R1 boot overlay and its boundary
    access("R1", 16'h0000, 0, 0, 2'd0, 1);
    access("R1", 16'h00FF, 0, 0, 2'd3, 1);
    access("R3", 16'h0100, 0, 0, 2'd0, 1);
    access("R1", 16'h0010, 1, 8'h5A, 2'd0, 1);
    // R2 zero write keeps overlay, nonzero write drops it
    access("R2", 16'hFF50, 1, 8'h00, 2'd0, 1);
    access("R2", 16'h0020, 0, 0, 2'd0, 1);
    access("R2", 16'hFF50, 1, 8'h01, 2'd0, 1);
    access("R2", 16'h0020, 0, 0, 2'd0, 1);
    access("R2", 16'h00FF, 0, 0, 2'd0, 1);
    // R3 no cartridge
    access("R3", 16'h4000, 0, 0, 2'd0, 0);
    access("R3", 16'h7FFF, 1, 8'h33, 2'd0, 0);
    access("R3", 16'hA000, 0, 0, 2'd0, 0);
    access("R3", 16'hBFFF, 0, 0, 2'd0, 1);
    // R4 work RAM banks
    access("R4", 16'hC000, 0, 0, 2'd0, 1);
    access("R4", 16'hCFFF, 1, 8'h12, 2'd3, 1);
    access("R4", 16'hD000, 0, 0, 2'd2, 1);
    access("R4", 16'hDFFF, 0, 0, 2'd1, 1);
    // R5 echo mirror
    access("R5", 16'hE000, 0, 0, 2'd0, 1);
    access("R5", 16'hEFFF, 0, 0, 2'd0, 1);
    access("R5", 16'hF000, 1, 8'h44, 2'd0, 1);
    access("R5", 16'hFDFF, 0, 0, 2'd0, 1);
    // R6 video RAM gating in every mode
    for (int m = 0; m < 4; m++) begin
      access("R6", 16'h8000, 0, 0, 2'(m), 1);
      access("R6", 16'h9FFF, 1, 8'h77, 2'(m), 1);
    end
    // R7 sprite table, R8 prohibited gap
    for (int m = 0; m < 4; m++) begin
      access("R7", 16'hFE00, 0, 0, 2'(m), 1);
      access("R7", 16'hFE9F, 1, 8'h66, 2'(m), 1);
      access("R8", 16'hFEA0, 0, 0, 2'(m), 1);
      access("R8", 16'hFEFF, 1, 8'h55, 2'(m), 1);
    end
    // R9 I/O page
    access("R9", 16'hFF00, 0, 0, 2'd0, 1);
    access("R9", 16'hFF03, 0, 0, 2'd0, 1);
    access("R9", 16'hFF03, 1, 8'h09, 2'd0, 1);
    access("R9", 16'hFF4B, 0, 0, 2'd0, 1);
    access("R9", 16'hFF4C, 0, 0, 2'd0, 1);
    access("R9", 16'hFF7F, 0, 0, 2'd0, 1);
    // R10 high RAM and interrupt enable
    access("R10", 16'hFF80, 0, 0, 2'd3, 1);
    access("R10", 16'hFFFE, 0, 0, 2'd3, 1);
    access("R10", 16'hFFFF, 0, 0, 2'd3, 1);
    access("R10", 16'hFFFF, 1, 8'h1F, 2'd3, 1);

    // R2 reset restores overlay
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    mapped = 1'b1;
    check("R1", "reset rdData", 32'(rdData), 32'hFF);
    @(negedge clk);
    rstN = 1'b1;
    access("R2", 16'h0005, 0, 0, 2'd0, 1);

    // R11 random mix, with the low page and gated ranges favoured
    void'($urandom(32'hA5A5));
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [2:0] pick;
      pick = 3'($urandom);
      case (pick)
        3'd0: a = 16'h00FF & 16'($urandom);
        3'd1: a = 16'hFE00 | (16'h00FF & 16'($urandom));
        3'd2: a = 16'hFF00 | (16'h00FF & 16'($urandom));
        default: a = 16'($urandom);
      endcase
      if (n == 2500) a = 16'hFF50;
      access("R11", a, 1'($urandom), (n == 2500) ? 8'h80 : 8'($urandom),
             2'($urandom), 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule